// File: doc/BRIEF.md
# Fractional Multiply Execution Unit

This unit executes the three fractional 8-bit multiply operations of a small processor core: unsigned by unsigned, signed by signed, and signed by unsigned. The unit receives a 16-bit instruction word with a valid strobe. It decodes the word and presents two register-file read addresses. From the returned operand bytes it forms a 16-bit product. It commits that product, shifted left by one, to the fixed result pair at register indices 0 and 1.

The carry and zero status bits are updated in the same cycle as the write. A completion pulse follows one cycle later. A feature-enable input can disable the multiplier. A disabled operation still completes, but nothing is written. Words that are not fractional multiplies are reported on an unmatched pulse and have no other effect.

Top module: `fmul_exec`

## Requirements
- R1: A word is a fractional multiply only when bits 15:8 equal 0x03 and the pair {bit 7, bit 3} is not 00. The pair 01 selects unsigned x unsigned, 10 selects signed x signed, and 11 selects signed x unsigned.
- R2: Read address A is 16 + insn[6:4] and read address B is 16 + insn[2:0], both as 5-bit indices. Only registers 16 to 23 can be addressed.
- R3: Operands are extended according to the variant. Unsigned uses zero-extension of both operands. Signed uses sign-extension of both. Signed x unsigned sign-extends A and zero-extends B. The product is truncated to 16 bits.
- R4: The carry output takes bit 15 of the 16-bit product before the shift.
- R5: The zero output is 1 exactly when the 16-bit product is zero.
- R6: The result is the product shifted left by one, truncated to 16 bits. The low byte appears on `res_lo_o` (register 0) and the high byte on `res_hi_o` (register 1).
- R7: With `mul_en_i` low, a matching operation raises no write and no flag update, and the result and flag outputs hold. `done_o` still pulses.
- R8: For a valid matching enabled word sampled at edge N, `res_we_o` and `flag_we_o` are both high for the single cycle after edge N, with new values. `done_o` is high for the cycle after edge N+1. Back-to-back words are accepted every cycle.
- R9: A valid non-matching word raises `unmatched_o` for the cycle after its edge. It causes no write, no flag update and no `done_o`, and it leaves every held output unchanged.
- R10: After reset every output register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_i | input | 16 | Instruction word |
| insn_valid_i | input | 1 | Instruction valid strobe |
| mul_en_i | input | 1 | Multiplier feature enable |
| rd_addr_a_o | output | 5 | Register index of operand A |
| rd_data_a_i | input | 8 | Operand A byte |
| rd_addr_b_o | output | 5 | Register index of operand B |
| rd_data_b_i | input | 8 | Operand B byte |
| res_we_o | output | 1 | Write strobe for the result pair |
| res_lo_o | output | 8 | Byte for register 0 |
| res_hi_o | output | 8 | Byte for register 1 |
| flag_we_o | output | 1 | Carry and zero update strobe |
| flag_c_o | output | 1 | Carry flag |
| flag_z_o | output | 1 | Zero flag |
| done_o | output | 1 | Completion pulse |
| unmatched_o | output | 1 | Unrecognised-word pulse |

## Verification
A wrong internal state in this unit shows at the ports one cycle after the offending word. It appears as a wrong result byte, a wrong flag, a misplaced strobe, or a held value that moved when it should not have. It appears one cycle later still when the fault is in the completion pulse. Comparing every output on every cycle against a behavioural model catches a fault within two cycles of its cause. The operand sweep covers every A byte against a spread of B bytes for all three variants, together with the extreme products. This exposes faults in sign extension, in the carry tap and in the shift.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  localparam logic [7:0] FM_PREFIX = 8'h03;

  typedef enum logic [1:0] {
    FM_NONE = 2'b00,
    FM_UU   = 2'b01,
    FM_SS   = 2'b10,
    FM_SU   = 2'b11
  } fm_kind_e;
endpackage

// File: rtl/fmul_decode.sv
module fmul_decode #(
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 5,
  parameter int BASE   = 16
) (
  input  logic [15:0]       insn_i,
  output logic              hit_o,
  output logic              sign_a_o,
  output logic              sign_b_o,
  output logic [ADDR_W-1:0] addr_a_o,
  output logic [ADDR_W-1:0] addr_b_o
);
  import fmul_pkg::*;

  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

  fm_kind_e kind;

  always_comb begin
    kind = fm_kind_e'({insn_i[7], insn_i[3]});
    hit_o = (insn_i[15:8] == FM_PREFIX) && (kind != FM_NONE);
    sign_a_o = (kind == FM_SS) || (kind == FM_SU);
    sign_b_o = (kind == FM_SS);
    addr_a_o = BASE_V + ADDR_W'(insn_i[4 +: IDX_W]);
    addr_b_o = BASE_V + ADDR_W'(insn_i[0 +: IDX_W]);
  end
endmodule

// File: rtl/fmul_core.sv
module fmul_core #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            sign_a_i,
  input  logic            sign_b_i,
  output logic [2*DW-1:0] res_o,
  output logic            carry_o,
  output logic            zero_o
);
  localparam int PW = 2 * DW;

  logic signed [DW:0]   xa, xb;
  logic signed [PW+1:0] full;
  logic [PW-1:0]        prod;

  always_comb begin
    xa = $signed({sign_a_i & a_i[DW-1], a_i});
    xb = $signed({sign_b_i & b_i[DW-1], b_i});
    full = xa * xb;
    prod = full[PW-1:0];
    carry_o = prod[PW-1];          // taken before the shift
    zero_o = (prod == '0);
    res_o = {prod[PW-2:0], 1'b0};
  end
endmodule

// File: rtl/fmul_retire.sv
module fmul_retire #(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            hit_i,
  input  logic            en_i,
  input  logic [2*DW-1:0] res_i,
  input  logic            carry_i,
  input  logic            zero_i,
  output logic            res_we_o,
  output logic [DW-1:0]   res_lo_o,
  output logic [DW-1:0]   res_hi_o,
  output logic            flag_we_o,
  output logic            flag_c_o,
  output logic            flag_z_o,
  output logic            done_o,
  output logic            unmatched_o
);
  logic commit_q, pend_q, done_q, unm_q, c_q, z_q;
  logic [2*DW-1:0] res_q;
  logic commit_d;

  assign commit_d = valid_i & hit_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q <= 1'b0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
      unm_q    <= 1'b0;
      res_q    <= '0;
      c_q      <= 1'b0;
      z_q      <= 1'b0;
    end else begin
      commit_q <= commit_d;
      pend_q   <= valid_i & hit_i;
      done_q   <= pend_q;
      unm_q    <= valid_i & ~hit_i;
      if (commit_d) begin
        res_q <= res_i;
        c_q   <= carry_i;
        z_q   <= zero_i;
      end
    end
  end

  assign res_we_o    = commit_q;
  assign flag_we_o   = commit_q;
  assign res_lo_o    = res_q[DW-1:0];
  assign res_hi_o    = res_q[2*DW-1:DW];
  assign flag_c_o    = c_q;
  assign flag_z_o    = z_q;
  assign done_o      = done_q;
  assign unmatched_o = unm_q;

  p_commit_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> ($past(en_i) && $past(valid_i)));
  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_o |-> ($stable(res_q) && $stable(flag_c_o) && $stable(flag_z_o)));
  p_done_late_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(valid_i, 2) && $past(hit_i, 2)));
  p_unmatched_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmatched_o |-> (!res_we_o && !flag_we_o && $stable(res_q)));
  p_zero_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_o && flag_z_o) |-> (!flag_c_o && res_q == '0));
  p_shift_lsb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> !res_lo_o[0]);
endmodule

// File: rtl/fmul_exec.sv
module fmul_exec #(
  parameter int DW     = 8,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 5,
  parameter int BASE   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       insn_i,
  input  logic              insn_valid_i,
  input  logic              mul_en_i,
  output logic [ADDR_W-1:0] rd_addr_a_o,
  input  logic [DW-1:0]     rd_data_a_i,
  output logic [ADDR_W-1:0] rd_addr_b_o,
  input  logic [DW-1:0]     rd_data_b_i,
  output logic              res_we_o,
  output logic [DW-1:0]     res_lo_o,
  output logic [DW-1:0]     res_hi_o,
  output logic              flag_we_o,
  output logic              flag_c_o,
  output logic              flag_z_o,
  output logic              done_o,
  output logic              unmatched_o
);
  logic hit, sign_a, sign_b, carry, zero;
  logic [2*DW-1:0] res;

  fmul_decode #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
    .insn_i   (insn_i),
    .hit_o    (hit),
    .sign_a_o (sign_a),
    .sign_b_o (sign_b),
    .addr_a_o (rd_addr_a_o),
    .addr_b_o (rd_addr_b_o)
  );

  fmul_core #(.DW(DW)) u_core (
    .a_i      (rd_data_a_i),
    .b_i      (rd_data_b_i),
    .sign_a_i (sign_a),
    .sign_b_i (sign_b),
    .res_o    (res),
    .carry_o  (carry),
    .zero_o   (zero)
  );

  fmul_retire #(.DW(DW)) u_retire (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (insn_valid_i),
    .hit_i       (hit),
    .en_i        (mul_en_i),
    .res_i       (res),
    .carry_i     (carry),
    .zero_i      (zero),
    .res_we_o    (res_we_o),
    .res_lo_o    (res_lo_o),
    .res_hi_o    (res_hi_o),
    .flag_we_o   (flag_we_o),
    .flag_c_o    (flag_c_o),
    .flag_z_o    (flag_z_o),
    .done_o      (done_o),
    .unmatched_o (unmatched_o)
  );

  p_bank_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_i |-> (rd_addr_a_o >= ADDR_W'(BASE) && rd_addr_b_o >= ADDR_W'(BASE)));
endmodule

// File: tb/fmul_exec_tb.sv
module fmul_exec_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] insn = 16'h0;
  logic valid = 1'b0;
  logic en = 1'b1;
  logic [4:0] ra, rb;
  logic [7:0] da, db;
  logic we, fwe, c, z, done, unm;
  logic [7:0] lo, hi;
  logic [7:0] rf [32];

  int vecs = 0;
  int fails = 0;
  int cycles = 0;
  string ph = "R10";

  int e_we, e_fwe, e_c, e_z, e_done, e_pend, e_unm, e_res;

  always #2.5 clk = ~clk;

  assign da = rf[ra];
  assign db = rf[rb];

  fmul_exec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .insn_i(insn), .insn_valid_i(valid),
    .mul_en_i(en), .rd_addr_a_o(ra), .rd_data_a_i(da), .rd_addr_b_o(rb),
    .rd_data_b_i(db), .res_we_o(we), .res_lo_o(lo), .res_hi_o(hi),
    .flag_we_o(fwe), .flag_c_o(c), .flag_z_o(z), .done_o(done),
    .unmatched_o(unm)
  );

  task automatic chk(input int got, input int exp, input string tag);
    vecs++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cycles, got, exp);
    end
  endtask

  // behavioural reference, evaluated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_we = 0; e_fwe = 0; e_c = 0; e_z = 0; e_done = 0; e_pend = 0; e_unm = 0; e_res = 0;
    end else begin
      int kind, av, bv, p;
      e_done = e_pend;
      e_pend = 0; e_we = 0; e_fwe = 0; e_unm = 0;
      if (valid) begin
        kind = {insn[7], insn[3]};
        if (insn[15:8] == 8'h03 && kind != 0) begin
          e_pend = 1;
          if (en) begin
            av = rf[16 + insn[6:4]];
            bv = rf[16 + insn[2:0]];
            if (kind != 1 && av > 127) av -= 256;
            if (kind == 2 && bv > 127) bv -= 256;
            p = (av * bv) & 32'hFFFF;
            e_c = (p >> 15) & 1;
            e_z = (p == 0) ? 1 : 0;
            e_res = (p << 1) & 32'hFFFF;
            e_we = 1; e_fwe = 1;
          end
        end else e_unm = 1;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    chk(we, e_we, {"R8 ", ph});
    chk(fwe, e_fwe, {"R8 ", ph});
    chk(done, e_done, {"R8 ", ph});
    chk(unm, e_unm, {"R9 ", ph});
    chk({hi, lo}, e_res, {"R6 R3 ", ph});
    chk(c, e_c, {"R4 ", ph});
    chk(z, e_z, {"R5 ", ph});
    if (valid) begin
      chk(ra, 16 + insn[6:4], "R2 addr A");
      chk(rb, 16 + insn[2:0], "R2 addr B");
    end
  end

  // drive one word; kind {b7,b3}, operand indices distinct unless equal values given
  task automatic issue(input int kind, input int a, input int b, input int ia, input int ib,
                       input bit v, input bit e);
    @(negedge clk);
    #1;
    insn = {8'h03, kind[1], ia[2:0], kind[0], ib[2:0]};
    rf[16 + ia] = a[7:0];
    rf[16 + ib] = b[7:0];
    valid = v;
    en = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      valid = 1'b0;
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 8'(i * 7);
    repeat (3) @(negedge clk);
    ph = "R10 reset";
    chk({we, fwe, done, unm, c, z, hi, lo}, 0, "R10 reset state");
    rst_n = 1'b1;
    idle(2);

    ph = "R3 corners";
    issue(2, 128, 128, 0, 1, 1, 1);   // -128 x -128
    issue(1, 255, 255, 2, 3, 1, 1);   // 255 x 255
    issue(3, 128, 255, 4, 5, 1, 1);   // -128 x 255
    issue(3, 255, 255, 6, 7, 1, 1);
    issue(2, 0, 200, 1, 0, 1, 1);     // zero product
    issue(1, 128, 128, 5, 5, 1, 1);   // same register twice
    issue(2, 127, 129, 7, 6, 1, 1);
    idle(3);

    ph = "R1 sweep";
    for (int k = 1; k < 4; k++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 3)
          issue(k, a, b, a % 8, (a + 1 + b) % 8 == a % 8 ? (a + 2) % 8 : (a + 1 + b) % 8, 1, 1);
    idle(3);

    ph = "R7 disabled";
    issue(1, 255, 255, 0, 1, 1, 1);
    issue(2, 3, 5, 2, 3, 1, 0);
    issue(3, 128, 1, 4, 5, 1, 0);
    idle(3);
    issue(1, 9, 9, 0, 0, 1, 0);
    issue(2, 0, 0, 1, 2, 1, 1);
    idle(3);

    ph = "R9 unmatched";
    issue(1, 200, 201, 3, 4, 1, 1);
    idle(1);
    for (int w = 0; w < 12; w++) begin
      @(negedge clk);
      #1;
      insn = (w < 4) ? {8'h03, 1'b0, 3'(w), 1'b0, 3'(w)} : 16'((w * 16'h1357) ^ 16'h0088);
      if (insn[15:8] == 8'h03) insn[15:8] = 8'h13;
      if (w < 4) insn[15:8] = 8'h03;
      valid = 1'b1;
      en = 1'b1;
    end
    idle(2);
    ph = "R1 invalid word";
    issue(3, 5, 6, 0, 1, 0, 1);
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule